// File: doc/BRIEF.md
# Low-Voltage Detect Control Register

This block is a one-byte control and status register that sits beside a supply comparator. The comparator's verdict arrives as a synchronous digital level. When monitoring is armed and a low supply is seen, the block latches a sticky flag. Software clears the flag by writing a one to a separate acknowledge bit.

The flag fans out to an interrupt request and a system reset request. Each route has its own enable, and the master enable gates both. A further bit decides whether detection keeps running while the chip is in STOP. Another bit drives the band gap reference buffer enable.

The master enable, the reset route enable and the STOP enable are configuration bits that can be written once. The first register write after reset fixes them, and only a reset reopens them. The register port is a plain write strobe with a combinational read-back, with no flow control. The comparator, STOP and reset pins are plain levels.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After reset the read value is 0x14: master enable (bit 2) = 1, reset route enable (bit 4) = 1, and all other bits 0. The interrupt, reset request and band gap outputs are all low.
- R2: Bit 7 is the detect flag. It becomes 1 on the clock edge after a cycle in which low_volt_i = 1 and detection is active. Writing 1 to bit 7 never sets it.
- R3: Writing 1 to bit 6 clears the flag at the next edge, unless a detection happens in the same cycle. Bit 6 always reads 0.
- R4: lv_irq_o is 1 exactly while the flag, the interrupt enable (bit 5) and the master enable are all 1. With bit 5 = 0 the flag is only visible by polling bit 7.
- R5: lv_rst_req_o is 1 exactly while the flag, the reset route enable (bit 4) and the master enable are all 1.
- R6: When stop_mode_i = 1, a low_volt_i pulse is ignored if the STOP enable (bit 3) is 0. It sets the flag if bit 3 is 1.
- R7: With the master enable at 0, low_volt_i never sets the flag, and both request outputs stay low even if the flag is already set.
- R8: Bit 1 always reads 0, and writes to it are ignored.
- R9: Bit 0 drives bg_buf_en_o. Bit 0 and bit 5 accept every write.
- R10: Bits 4, 3 and 2 each take their value from the first register write after reset. Later writes leave them unchanged until the next reset.
- R11: If a detection and an acknowledge write fall in the same cycle, the flag is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Current register value |
| low_volt_i | input | 1 | Synchronous low-supply indication |
| stop_mode_i | input | 1 | Chip is in STOP mode |
| lv_irq_o | output | 1 | Low-voltage interrupt request |
| lv_rst_req_o | output | 1 | System reset request |
| bg_buf_en_o | output | 1 | Band gap buffer enable |

## Verification
The flag path is driven with low-voltage pulses under four gating conditions: run mode, STOP with the STOP enable clear, STOP with it set, and master enable off. Comparing these separates the master gate from the STOP gate.

Acknowledge writes are issued both alone and in the same cycle as a pulse. This tells clear-wins from set-wins behaviour.

Sequences of writes with differing data show which bits lock after the first write and which stay writable. Writes that carry ones in the flag and reserved positions confirm those bits cannot be forced.

Starting from the reset defaults, a pulse is shown to raise the reset request before any write. A first write of zeros while the flag is set then shows the routes being gated off without the flag being lost.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int REG_W    = 8;
  // bit positions of the register image
  localparam int B_FLAG   = 7;
  localparam int B_ACK    = 6;
  localparam int B_IRQEN  = 5;
  localparam int B_RSTEN  = 4;
  localparam int B_STOPEN = 3;
  localparam int B_MEN    = 2;
  localparam int B_RSV    = 1;
  localparam int B_BGEN   = 0;
  // write-once group, index order: 0 = master, 1 = stop, 2 = reset route
  localparam int N_ONCE   = 3;
  localparam int N_FREE   = 2;  // index 0 = band gap, 1 = irq enable

  typedef struct packed {
    logic irq_en;
    logic rst_en;
    logic stop_en;
    logic mst_en;
    logic bg_en;
  } lvd_cfg_t;
endpackage

// File: rtl/lvd_cfg_bank.sv
module lvd_cfg_bank
  import lvd_pkg::*;
#(
  parameter logic [N_ONCE-1:0] ONCE_RST = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [N_ONCE-1:0] once_wd,
  input  logic [N_FREE-1:0] free_wd,
  output lvd_cfg_t          cfg_o
);
  logic [N_ONCE-1:0] once_q;
  logic [N_ONCE-1:0] lock_q;
  logic [N_FREE-1:0] free_q;

  genvar gi;
  generate
    for (gi = 0; gi < N_ONCE; gi++) begin : g_once
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          once_q[gi] <= ONCE_RST[gi];
          lock_q[gi] <= 1'b0;
        end else if (wr_en && !lock_q[gi]) begin
          once_q[gi] <= once_wd[gi];
          lock_q[gi] <= 1'b1;
        end
      end

      AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[gi] |=> $stable(once_q[gi])); // R10
      AST_FIRST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock_q[gi]) |=> (once_q[gi] == $past(once_wd[gi]))); // R10
    end

    for (gi = 0; gi < N_FREE; gi++) begin : g_free
      always_ff @(posedge clk) begin
        if (!rst_n)     free_q[gi] <= 1'b0;
        else if (wr_en) free_q[gi] <= free_wd[gi];
      end
    end
  endgenerate

  always_comb begin
    cfg_o.mst_en  = once_q[0];
    cfg_o.stop_en = once_q[1];
    cfg_o.rst_en  = once_q[2];
    cfg_o.bg_en   = free_q[0];
    cfg_o.irq_en  = free_q[1];
  end
endmodule

// File: rtl/lvd_flag.sv
module lvd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mst_en,
  input  logic stop_en,
  input  logic stop_mode,
  input  logic low_volt,
  input  logic ack,
  output logic flag_q,
  output logic det_hit
);
  logic active;

  always_comb begin
    active  = mst_en && (!stop_mode || stop_en);
    det_hit = active && low_volt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (det_hit) flag_q <= 1'b1;  // detection outranks acknowledge
    else if (ack)     flag_q <= 1'b0;
  end

  AST_SET_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(mst_en && low_volt)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(mst_en && low_volt && (!stop_mode || stop_en))) |=> !flag_q); // R3
  AST_STOP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !stop_en) |=> !$rose(flag_q)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && low_volt && mst_en && (!stop_mode || stop_en)) |=> flag_q); // R11
endmodule

// File: rtl/lvd_route.sv
module lvd_route
  import lvd_pkg::*;
(
  input  logic             flag,
  input  lvd_cfg_t         cfg,
  output logic             irq,
  output logic             rst_req,
  output logic             bg_en,
  output logic [REG_W-1:0] rd_data
);
  always_comb begin
    irq      = flag && cfg.irq_en && cfg.mst_en;
    rst_req  = flag && cfg.rst_en && cfg.mst_en;
    bg_en    = cfg.bg_en;
    rd_data  = '0;
    rd_data[B_FLAG]   = flag;
    rd_data[B_IRQEN]  = cfg.irq_en;
    rd_data[B_RSTEN]  = cfg.rst_en;
    rd_data[B_STOPEN] = cfg.stop_en;
    rd_data[B_MEN]    = cfg.mst_en;
    rd_data[B_BGEN]   = cfg.bg_en;
  end
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
  import lvd_pkg::*;
#(
  parameter logic MEN_RST    = 1'b1,
  parameter logic RSTEN_RST  = 1'b1,
  parameter logic STOPEN_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             low_volt_i,
  input  logic             stop_mode_i,
  output logic             lv_irq_o,
  output logic             lv_rst_req_o,
  output logic             bg_buf_en_o
);
  localparam logic [N_ONCE-1:0] ONCE_RST = {RSTEN_RST, STOPEN_RST, MEN_RST};

  lvd_cfg_t          cfg;
  logic              flag;
  logic              det_hit;
  logic              ack;
  logic [N_ONCE-1:0] once_wd;
  logic [N_FREE-1:0] free_wd;

  always_comb begin
    once_wd = {reg_wr_data[B_RSTEN], reg_wr_data[B_STOPEN], reg_wr_data[B_MEN]};
    free_wd = {reg_wr_data[B_IRQEN], reg_wr_data[B_BGEN]};
    ack     = reg_wr_en && reg_wr_data[B_ACK];
  end

  lvd_cfg_bank #(.ONCE_RST(ONCE_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .once_wd (once_wd),
    .free_wd (free_wd),
    .cfg_o   (cfg)
  );

  lvd_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_en    (cfg.mst_en),
    .stop_en   (cfg.stop_en),
    .stop_mode (stop_mode_i),
    .low_volt  (low_volt_i),
    .ack       (ack),
    .flag_q    (flag),
    .det_hit   (det_hit)
  );

  lvd_route u_route (
    .flag    (flag),
    .cfg     (cfg),
    .irq     (lv_irq_o),
    .rst_req (lv_rst_req_o),
    .bg_en   (bg_buf_en_o),
    .rd_data (reg_rd_data)
  );

  AST_RO_FLAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[B_FLAG] && !det_hit) |=> !$rose(reg_rd_data[B_FLAG])); // R2
  AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[B_RSV]) |=> !reg_rd_data[B_RSV]); // R8
  AST_RST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    lv_rst_req_o |-> (reg_rd_data[B_MEN] && reg_rd_data[B_FLAG])); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    lv_irq_o |-> (reg_rd_data[B_MEN] && reg_rd_data[B_IRQEN])); // R4
endmodule

// File: tb/lvd_ctrl_reg_tb.sv
module lvd_ctrl_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       low_volt_i = 1'b0;
  logic       stop_mode_i = 1'b0;
  logic       lv_irq_o, lv_rst_req_o, bg_buf_en_o;
  int         checks = 0;
  int         errors = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  lvd_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .low_volt_i(low_volt_i), .stop_mode_i(stop_mode_i),
    .lv_irq_o(lv_irq_o), .lv_rst_req_o(lv_rst_req_o), .bg_buf_en_o(bg_buf_en_o)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic       lv;
    logic       stop;
    logic [7:0] rd;
    logic       irq;
    logic       rst;
    logic       bg;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h14, 1'b0, 1'b0, 1'b0}, // R1 idle
    '{1'b1, 8'h2F, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0, 1'b1}, // R10 first write, R8 bit1, R9
    '{1'b1, 8'hDF, 1'b0, 1'b0, 8'h0D, 1'b0, 1'b0, 1'b1}, // R10 locked, R2 bit7 write ignored
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h8D, 1'b0, 1'b0, 1'b1}, // R2 set, R4 polling
    '{1'b1, 8'h21, 1'b0, 1'b0, 8'hAD, 1'b1, 1'b0, 1'b1}, // R4 irq enabled
    '{1'b1, 8'h61, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0, 1'b1}, // R3 ack clears
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'hAD, 1'b1, 1'b0, 1'b1}, // R6 detect in STOP
    '{1'b1, 8'h61, 1'b1, 1'b0, 8'hAD, 1'b1, 1'b0, 1'b1}, // R11 set beats ack
    '{1'b1, 8'h61, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0, 1'b1}, // R3 ack clears
    '{1'b1, 8'h20, 1'b0, 1'b0, 8'h2C, 1'b0, 1'b0, 1'b0}  // R9 band gap off
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [7:0] rd, input logic irq,
                         input logic rst, input logic bg);
    chk({req, " rd"}, reg_rd_data, rd);
    chk({req, " irq"}, {7'd0, lv_irq_o}, {7'd0, irq});
    chk({req, " rst_req"}, {7'd0, lv_rst_req_o}, {7'd0, rst});
    chk({req, " bg"}, {7'd0, bg_buf_en_o}, {7'd0, bg});
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic lv, input logic stop);
    @(negedge clk);
    reg_wr_en = wr; reg_wr_data = wd; low_volt_i = lv; stop_mode_i = stop;
    @(posedge clk);
    #1;
    reg_wr_en = 1'b0; reg_wr_data = 8'h00; low_volt_i = 1'b0; stop_mode_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk_all("R1 reset", 8'h14, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].wd, VECS[i].lv, VECS[i].stop);
      chk_all($sformatf("vector %0d", i), VECS[i].rd, VECS[i].irq, VECS[i].rst, VECS[i].bg);
    end

    // R5 default route, then a first write that disables monitoring (R7, R10)
    do_reset();
    chk_all("R1 reset again", 8'h14, 1'b0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk_all("R5 default reset request", 8'h94, 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h40, 1'b0, 1'b0);
    chk_all("R3 R10 ack as first write", 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk_all("R7 no detect when disabled", 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b1, 8'h3F, 1'b0, 1'b0);
    chk_all("R10 R9 locked bits stay", 8'h21, 1'b0, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk_all("R7 still no detect", 8'h21, 1'b0, 1'b0, 1'b1);

    // R6 STOP gating with STOP enable clear
    do_reset();
    step(1'b1, 8'h34, 1'b0, 1'b0);
    chk_all("R10 configure", 8'h34, 1'b0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    chk_all("R6 ignored in STOP", 8'h34, 1'b0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk_all("R4 R5 both routes", 8'hB4, 1'b1, 1'b1, 1'b0);

    // R7 routes gated once master enable drops with flag set
    do_reset();
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk_all("R2 set from defaults", 8'h94, 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0);
    chk_all("R7 routes gated, flag kept", 8'h80, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule